// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the bus-side command interpreter of a NOR-style flash memory model. It watches the asynchronous chip interface (chip enable, write enable, output enable, address, data), which it samples with its own clock, and turns recognised multi-cycle write sequences into one-cycle requests for an abstract array controller. The requests are program, sector erase, chip erase, erase suspend and erase resume. A request that targets write-protected storage comes out as a reject pulse instead.

Two unlock writes come before every normal command. A bypass mode shortens programming to a command write followed by a data write. A hardware accelerate input places the decoder in that mode directly. An autoselect mode redirects reads to an identification register, and a busy input from the array controller holds off every command except suspend.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A bus write is taken only while chip enable and write enable are both low and output enable is high. Each such assertion counts once, in the first clock where the condition holds, however long it is held.
- R2: In read-array state, the writes 0x555/0xAA, 0x2AA/0x55 and 0x555/0xA0, followed by a write of address A and data D, give one req_prog_o pulse carrying A and D. The pulse is visible in the clock cycle after the fourth write is taken.
- R3: A write that does not match the next expected step of a sequence returns the decoder to read-array state without issuing a request.
- R4: After reset the decoder is in read-array state: no request, bypass_o and idmode_o low, and rd_data_o equal to array_rd_i. A write of data 0xF0 in any command state returns it to read-array state. This includes autoselect, but not a program data cycle.
- R5: The unlock pair followed by 0x555/0x20 enters bypass mode (bypass_o high). In bypass mode, 0xA0 at any address followed by a write of A/D programs A with D. 0x80 followed by 0x30 at A erases the sector of A. 0x80 followed by 0x10 at 0x555 erases the chip. 0xF0 leaves the decoder in bypass mode.
- R6: In bypass mode, a write of 0x90 followed by a write of 0x00 returns the decoder to read-array state.
- R7: While accel_i is high, a decoder in read-array state moves to bypass mode without any write, within two clock cycles.
- R8: The sector is the top SB address bits (bits 11:9 by default). While wp_n_i is low, sectors with an index below PROT_SECT (0 and 1 by default) are protected. A program or sector erase aimed at one of them gives req_reject_o with the target address instead. While wp_n_i is low, chip erase is always rejected. Both rules hold in normal and in bypass mode.
- R9: The sequence unlock pair, 0x555/0x80, unlock pair, then 0x30 at address A gives req_serase_o with A. The same sequence ending in 0x10 at 0x555 gives req_cerase_o.
- R10: While array_busy_i is high, every write except data 0xB0 is ignored and the sequence state is kept. A write of 0xB0 gives req_susp_o and marks the erase suspended.
- R11: A write of 0x30 in read-array or bypass idle state gives req_resume_o only while an erase is suspended, and clears the suspended mark.
- R12: The unlock pair followed by 0x555/0x90 enters autoselect (idmode_o high). Other writes there are ignored. rd_data_o then depends on address bits 1:0: 0 returns MFR_CODE, 1 returns DEV_CODE, 2 returns the protection status of the addressed sector in bit 0, and 3 returns zero. Outside autoselect, rd_data_o is array_rd_i.
- R13: Every request output is a single-cycle pulse, and at most one request output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr_i | input | AW | Bus address |
| bus_data_i | input | DW | Bus write data (command in bits 7:0) |
| accel_i | input | 1 | Accelerate request, forces bypass mode |
| wp_n_i | input | 1 | Write protect, active low |
| array_busy_i | input | 1 | Array controller busy |
| array_rd_i | input | DW | Array read data |
| req_prog_o | output | 1 | Program request pulse |
| req_serase_o | output | 1 | Sector erase request pulse |
| req_cerase_o | output | 1 | Chip erase request pulse |
| req_susp_o | output | 1 | Erase suspend pulse |
| req_resume_o | output | 1 | Erase resume pulse |
| req_reject_o | output | 1 | Protected target rejected pulse |
| req_addr_o | output | AW | Address carried with a request |
| req_data_o | output | DW | Data carried with a request |
| bypass_o | output | 1 | Bypass mode active |
| idmode_o | output | 1 | Autoselect mode active |
| rd_data_o | output | DW | Read data, identification or array |

## Verification
The hardest case to reach from the ports is a busy period that falls in the middle of an unlock sequence. The sequence state must survive ignored writes and a suspend, and then finish into a correct request. The stimulus starts a sequence and raises busy after its first write. It then sends a write that would break the sequence if it were accepted, followed by a suspend, and completes the sequence once busy drops. A wrongly accepted write shows up as a missing or wrong program request in the scoreboard. Resume is then tried twice, so that the second, unsuspended attempt must produce no pulse.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_PROG_DATA,
        S_ERS1,
        S_ERS2,
        S_ERS3,
        S_ID,
        S_BYP,
        S_BYP_PROG,
        S_BYP_ERS,
        S_BYP_EXIT
    } fcd_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_PROG,
        K_SERASE,
        K_CERASE,
        K_SUSP,
        K_RESUME,
        K_REJECT
    } fcd_kind_e;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_ABORT   = 8'hF0;
    localparam logic [7:0] CMD_LEAVE   = 8'h00;

    localparam logic [10:0] ADDR_KEY1 = 11'h555;
    localparam logic [10:0] ADDR_KEY2 = 11'h2AA;

endpackage

// File: rtl/fcd_bus_sampler.sv
`timescale 1ns/1ps
module fcd_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_stb
);
    logic wr_act;
    logic act_d, act_q;

    assign wr_act = !ce_n && !we_n && oe_n;

    always_comb begin
        act_d = wr_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end

    assign wr_stb = wr_act && !act_q;

    // R1: one strobe per held write
    p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/fcd_sector_guard.sv
`timescale 1ns/1ps
module fcd_sector_guard #(
    parameter int SB        = 3,
    parameter int PROT_SECT = 2
) (
    input  logic          wp_n,
    input  logic [SB-1:0] sector,
    output logic          sect_prot,
    output logic          any_prot
);
    localparam logic [SB:0] PLIM = (SB+1)'(PROT_SECT);

    assign sect_prot = !wp_n && ({1'b0, sector} < PLIM);
    assign any_prot  = !wp_n && (PLIM != '0);
endmodule

// File: rtl/fcd_id_mux.sv
`timescale 1ns/1ps
module fcd_id_mux #(
    parameter int              DW       = 16,
    parameter logic [DW-1:0]   MFR_CODE = 16'h0001,
    parameter logic [DW-1:0]   DEV_CODE = 16'h2A7E
) (
    input  logic          id_mode,
    input  logic [1:0]    sel,
    input  logic          sect_prot,
    input  logic [DW-1:0] array_rd,
    output logic [DW-1:0] rd_data
);
    always_comb begin
        if (!id_mode) begin
            rd_data = array_rd;
        end else begin
            unique case (sel)
                2'd0:    rd_data = MFR_CODE;
                2'd1:    rd_data = DEV_CODE;
                2'd2:    rd_data = DW'(sect_prot);
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int            AW        = 12,
    parameter int            DW        = 16,
    parameter int            SB        = 3,
    parameter int            PROT_SECT = 2,
    parameter logic [DW-1:0] MFR_CODE  = 16'h0001,
    parameter logic [DW-1:0] DEV_CODE  = 16'h2A7E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_ce_n,
    input  logic          bus_we_n,
    input  logic          bus_oe_n,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_data_i,
    input  logic          accel_i,
    input  logic          wp_n_i,
    input  logic          array_busy_i,
    input  logic [DW-1:0] array_rd_i,
    output logic          req_prog_o,
    output logic          req_serase_o,
    output logic          req_cerase_o,
    output logic          req_susp_o,
    output logic          req_resume_o,
    output logic          req_reject_o,
    output logic [AW-1:0] req_addr_o,
    output logic [DW-1:0] req_data_o,
    output logic          bypass_o,
    output logic          idmode_o,
    output logic [DW-1:0] rd_data_o
);
    localparam logic [SB:0] PLIM = (SB+1)'(PROT_SECT);

    typedef struct packed {
        fcd_state_e    st;
        logic          susp;
        fcd_kind_e     kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } regs_t;

    regs_t d, q;

    logic       wr_stb;
    logic       sect_prot;
    logic       any_prot;
    logic [7:0] cmd;
    logic       at_key1, at_key2;
    logic       in_byp;

    fcd_bus_sampler i_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (bus_ce_n),
        .we_n   (bus_we_n),
        .oe_n   (bus_oe_n),
        .wr_stb (wr_stb)
    );

    fcd_sector_guard #(.SB(SB), .PROT_SECT(PROT_SECT)) i_guard (
        .wp_n      (wp_n_i),
        .sector    (bus_addr_i[AW-1 -: SB]),
        .sect_prot (sect_prot),
        .any_prot  (any_prot)
    );

    fcd_id_mux #(.DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) i_idmux (
        .id_mode   (q.st == S_ID),
        .sel       (bus_addr_i[1:0]),
        .sect_prot (sect_prot),
        .array_rd  (array_rd_i),
        .rd_data   (rd_data_o)
    );

    assign cmd     = bus_data_i[7:0];
    assign at_key1 = (bus_addr_i[10:0] == ADDR_KEY1);
    assign at_key2 = (bus_addr_i[10:0] == ADDR_KEY2);
    assign in_byp  = (q.st == S_BYP) || (q.st == S_BYP_PROG) ||
                     (q.st == S_BYP_ERS) || (q.st == S_BYP_EXIT);

    function automatic fcd_kind_e gate(input fcd_kind_e k, input logic blocked);
        return blocked ? K_REJECT : k;
    endfunction

    always_comb begin
        d      = q;
        d.kind = K_NONE;
        if (q.st == S_READ && accel_i) d.st = S_BYP;

        if (wr_stb) begin
            d.addr = bus_addr_i;
            d.data = bus_data_i;
            if (array_busy_i) begin
                if (cmd == CMD_SUSPEND && !q.susp) begin
                    d.kind = K_SUSP;
                    d.susp = 1'b1;
                end
            end else if (cmd == CMD_ABORT && q.st != S_PROG_DATA && q.st != S_BYP_PROG) begin
                d.st = in_byp ? S_BYP : S_READ;
            end else begin
                unique case (q.st)
                    S_READ: begin
                        if (cmd == CMD_KEY1 && at_key1) begin
                            d.st = S_UNL1;
                        end else if (cmd == CMD_SECTOR && q.susp) begin
                            d.kind = K_RESUME;
                            d.susp = 1'b0;
                        end
                    end
                    S_UNL1: d.st = (cmd == CMD_KEY2 && at_key2) ? S_UNL2 : S_READ;
                    S_UNL2: begin
                        d.st = S_READ;
                        if (at_key1) begin
                            unique case (cmd)
                                CMD_PROG:   d.st = S_PROG_DATA;
                                CMD_ERASE:  d.st = S_ERS1;
                                CMD_IDENT:  d.st = S_ID;
                                CMD_BYPASS: d.st = S_BYP;
                                default:    d.st = S_READ;
                            endcase
                        end
                    end
                    S_PROG_DATA: begin
                        d.kind = gate(K_PROG, sect_prot);
                        d.st   = S_READ;
                    end
                    S_ERS1: d.st = (cmd == CMD_KEY1 && at_key1) ? S_ERS2 : S_READ;
                    S_ERS2: d.st = (cmd == CMD_KEY2 && at_key2) ? S_ERS3 : S_READ;
                    S_ERS3: begin
                        d.st = S_READ;
                        if (cmd == CMD_SECTOR)               d.kind = gate(K_SERASE, sect_prot);
                        else if (cmd == CMD_CHIP && at_key1) d.kind = gate(K_CERASE, any_prot);
                    end
                    S_ID: d.st = S_ID;
                    S_BYP: begin
                        if (cmd == CMD_PROG)       d.st = S_BYP_PROG;
                        else if (cmd == CMD_ERASE) d.st = S_BYP_ERS;
                        else if (cmd == CMD_IDENT) d.st = S_BYP_EXIT;
                        else if (cmd == CMD_SECTOR && q.susp) begin
                            d.kind = K_RESUME;
                            d.susp = 1'b0;
                        end
                    end
                    S_BYP_PROG: begin
                        d.kind = gate(K_PROG, sect_prot);
                        d.st   = S_BYP;
                    end
                    S_BYP_ERS: begin
                        d.st = S_BYP;
                        if (cmd == CMD_SECTOR)               d.kind = gate(K_SERASE, sect_prot);
                        else if (cmd == CMD_CHIP && at_key1) d.kind = gate(K_CERASE, any_prot);
                    end
                    S_BYP_EXIT: d.st = (cmd == CMD_LEAVE) ? S_READ : S_BYP;
                    default: d.st = S_READ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_READ;
            q.susp <= 1'b0;
            q.kind <= K_NONE;
            q.addr <= '0;
            q.data <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_prog_o   = (q.kind == K_PROG);
    assign req_serase_o = (q.kind == K_SERASE);
    assign req_cerase_o = (q.kind == K_CERASE);
    assign req_susp_o   = (q.kind == K_SUSP);
    assign req_resume_o = (q.kind == K_RESUME);
    assign req_reject_o = (q.kind == K_REJECT);
    assign req_addr_o   = q.addr;
    assign req_data_o   = q.data;
    assign bypass_o     = in_byp;
    assign idmode_o     = (q.st == S_ID);

    // R10: no array work is requested from a busy controller
    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_prog_o || req_serase_o || req_cerase_o) |-> !$past(array_busy_i));

    // R8: a protected sector is never sent to the array
    p_prot_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_prog_o || req_serase_o) |->
            !(!$past(wp_n_i) && ({1'b0, req_addr_o[AW-1 -: SB]} < PLIM)));

    // R8: chip erase only with protection released
    p_chip_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_cerase_o |-> ($past(wp_n_i) || (PLIM == '0)));

    // R11: resume only follows a suspend
    p_resume_after_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_resume_o |-> $past(q.susp));

    // R13: request pulses last one cycle
    p_prog_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_prog_o |=> !req_prog_o);

    // R7: accelerate leaves read-array state
    p_accel_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accel_i && $past(accel_i) && q.st == S_READ && !wr_stb) |=> bypass_o);

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          accel = 1'b0, wp_n = 1'b1, busy = 1'b0;
    logic [DW-1:0] arr = 16'hBEEF;
    logic          p_prog, p_ser, p_cer, p_susp, p_res, p_rej;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_data;
    logic          byp, idm;
    logic [DW-1:0] rd;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;

    typedef struct packed {
        logic [2:0]    kind;
        logic [AW-1:0] a;
        logic [DW-1:0] dt;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n),
        .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr_i(addr), .bus_data_i(data),
        .accel_i(accel), .wp_n_i(wp_n), .array_busy_i(busy), .array_rd_i(arr),
        .req_prog_o(p_prog), .req_serase_o(p_ser), .req_cerase_o(p_cer),
        .req_susp_o(p_susp), .req_resume_o(p_res), .req_reject_o(p_rej),
        .req_addr_o(r_addr), .req_data_o(r_data),
        .bypass_o(byp), .idmode_o(idm), .rd_data_o(rd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kinds: 1 prog, 2 sector erase, 3 chip erase, 4 suspend, 5 resume, 6 reject
    task automatic expect_req(input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] dt);
        sb.push_back({k, a, dt});
    endtask

    task automatic raw(input logic c, input logic w, input logic o,
                       input logic [AW-1:0] a, input logic [DW-1:0] dt, input int hold);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; addr = a; data = dt;
        repeat (hold) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] dt);
        raw(1'b0, 1'b0, 1'b1, a, dt, 1);
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(12'h555, 16'h0080);
        unlock();
    endtask

    // monitor: pops the scoreboard whenever a request pulse appears
    logic [2:0] prev_kind = 3'd0;
    always @(negedge clk) begin
        logic [2:0] k;
        int hot;
        item_t e;
        if (rst_n) begin
            hot = int'(p_prog) + int'(p_ser) + int'(p_cer) + int'(p_susp) + int'(p_res) + int'(p_rej);
            k = p_prog ? 3'd1 : p_ser ? 3'd2 : p_cer ? 3'd3 :
                p_susp ? 3'd4 : p_res ? 3'd5 : p_rej ? 3'd6 : 3'd0;
            if (hot > 1) begin
                errors++; checks++;
                $display("FAIL R13 actual=%0d pulses expected=1", hot);
            end
            if (k != 0) begin
                pulses++;
                checks++;
                if (prev_kind == k) begin
                    errors++;
                    $display("FAIL R13 actual=repeat kind %0d expected=single cycle", k);
                end else if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R3 actual=kind %0d addr %h expected=no request", k, r_addr);
                end else begin
                    e = sb.pop_front();
                    if (e.kind != k || e.a != r_addr || (k == 3'd1 && e.dt != r_data)) begin
                        errors++;
                        $display("FAIL R2/R5/R8/R9/R10/R11 actual=%0d/%h/%h expected=%0d/%h/%h",
                                 k, r_addr, r_data, e.kind, e.a, e.dt);
                    end
                end
            end
            prev_kind = k;
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        // R4: reset state
        chk("R4 reset bypass", 32'(byp), 0);
        chk("R4 reset idmode", 32'(idm), 0);
        chk("R4 reset prog", 32'(p_prog), 0);
        chk("R12 reset read", 32'(rd), 32'hBEEF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: four-cycle program
        unlock();
        wr(12'h555, 16'h00A0);
        expect_req(3'd1, 12'h7A4, 16'h1234);
        wr(12'h7A4, 16'h1234);

        // R1: writes with output enable low or chip enable high are ignored; long hold gives one write
        unlock();
        raw(1'b0, 1'b0, 1'b0, 12'h555, 16'h00A0, 1);
        raw(1'b1, 1'b0, 1'b1, 12'h555, 16'h00A0, 1);
        wr(12'h555, 16'h00A0);
        expect_req(3'd1, 12'h600, 16'hA55A);
        raw(1'b0, 1'b0, 1'b1, 12'h600, 16'hA55A, 4);
        chk("R1 held write counted once", 32'(pulses), 2);

        // R3: a broken sequence issues nothing
        snap = pulses;
        unlock();
        wr(12'h555, 16'h0077);
        wr(12'h555, 16'h00A0);
        wr(12'h700, 16'h1111);
        chk("R3 broken sequence", 32'(pulses), 32'(snap));

        // R4: 0xF0 aborts a sequence
        unlock();
        wr(12'h123, 16'h00F0);
        wr(12'h555, 16'h00A0);
        wr(12'h700, 16'h2222);
        chk("R4 abort", 32'(pulses), 32'(snap));

        // R12: autoselect
        unlock();
        wr(12'h555, 16'h0090);
        chk("R12 idmode", 32'(idm), 1);
        wp_n = 1'b0;
        addr = 12'h000; #1 chk("R12 mfr", 32'(rd), 32'h0001);
        addr = 12'h001; #1 chk("R12 dev", 32'(rd), 32'h2A7E);
        addr = 12'h002; #1 chk("R12 protect sector0", 32'(rd), 1);
        addr = 12'h402; #1 chk("R12 protect sector2", 32'(rd), 0);
        addr = 12'h003; #1 chk("R12 reserved", 32'(rd), 0);
        wp_n = 1'b1;
        wr(12'h555, 16'h00A0);
        chk("R12 writes ignored", 32'(idm), 1);
        wr(12'h000, 16'h00F0);
        chk("R4 leave autoselect", 32'(idm), 0);
        addr = 12'h000; #1 chk("R12 array read", 32'(rd), 32'hBEEF);

        // R9: sector and chip erase
        erase_prefix();
        expect_req(3'd2, 12'hC00, 16'h0030);
        wr(12'hC00, 16'h0030);
        erase_prefix();
        expect_req(3'd3, 12'h555, 16'h0010);
        wr(12'h555, 16'h0010);

        // R8: write protect
        wp_n = 1'b0;
        unlock(); wr(12'h555, 16'h00A0);
        expect_req(3'd6, 12'h100, 16'h3333);
        wr(12'h100, 16'h3333);
        erase_prefix();
        expect_req(3'd6, 12'h200, 16'h0030);
        wr(12'h200, 16'h0030);
        erase_prefix();
        expect_req(3'd6, 12'h555, 16'h0010);
        wr(12'h555, 16'h0010);
        unlock(); wr(12'h555, 16'h00A0);
        expect_req(3'd1, 12'h800, 16'h4444);
        wr(12'h800, 16'h4444);
        wp_n = 1'b1;

        // R5: bypass mode
        unlock(); wr(12'h555, 16'h0020);
        chk("R5 bypass on", 32'(byp), 1);
        wr(12'h000, 16'h00A0);
        expect_req(3'd1, 12'h9AB, 16'h4242);
        wr(12'h9AB, 16'h4242);
        wr(12'h000, 16'h0080);
        expect_req(3'd2, 12'hA00, 16'h0030);
        wr(12'hA00, 16'h0030);
        wr(12'h000, 16'h00F0);
        chk("R5 abort keeps bypass", 32'(byp), 1);
        // R6: bypass exit
        wr(12'h000, 16'h0090);
        wr(12'h000, 16'h0000);
        chk("R6 bypass off", 32'(byp), 0);
        snap = pulses;
        wr(12'h000, 16'h00A0);
        wr(12'h900, 16'h0001);
        chk("R6 two-cycle program gone", 32'(pulses), 32'(snap));

        // R7: accelerate input
        accel = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 accel bypass", 32'(byp), 1);
        wp_n = 1'b0;
        wr(12'h000, 16'h00A0);
        expect_req(3'd6, 12'h050, 16'h5555);
        wr(12'h050, 16'h5555);
        wp_n = 1'b1;
        wr(12'h000, 16'h00A0);
        expect_req(3'd1, 12'hF00, 16'h6666);
        wr(12'hF00, 16'h6666);
        accel = 1'b0;
        wr(12'h000, 16'h0090);
        wr(12'h000, 16'h0000);
        chk("R6 exit after accel", 32'(byp), 0);

        // R10: busy holds the sequence, only suspend passes
        wr(12'h555, 16'h00AA);
        busy = 1'b1;
        wr(12'h555, 16'h0012);
        expect_req(3'd4, 12'h345, 16'h00B0);
        wr(12'h345, 16'h00B0);
        busy = 1'b0;
        wr(12'h2AA, 16'h0055);
        wr(12'h555, 16'h00A0);
        expect_req(3'd1, 12'h444, 16'h7777);
        wr(12'h444, 16'h7777);
        // R11: resume only while suspended
        expect_req(3'd5, 12'h000, 16'h0030);
        wr(12'h000, 16'h0030);
        snap = pulses;
        wr(12'h000, 16'h0030);
        wr(12'h000, 16'h00B0);
        chk("R11 no second resume", 32'(pulses), 32'(snap));

        repeat (5) @(negedge clk);
        chk("R2 scoreboard drained", 32'(sb.size()), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule